// File: doc/BRIEF.md
# Memory Refresh Counter

This block holds the refresh counter of an 8-bit processor and produces the address and strobe used to refresh dynamic memory while an opcode fetch is in progress. A bus sequencer supplies a flag that marks an opcode-fetch machine cycle and the number of the current T-state (1 to 4). In the last two T-states of that cycle the block drives a 16-bit refresh address and pulls an active-low strobe. The address is made from the counter value in the low byte and the interrupt-vector register value in the high byte.

The counter advances by one at the end of every opcode fetch. Only its seven low bits take part in the count. The top bit stays at whatever value software last wrote. Software can write all eight bits through a load strobe and read the value back through a read request. Refresh adds no cycles to the fetch, because the strobe and address come straight from the current T-state.

Top module: `mem_refresh_counter`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, the counter holds 0x00, `refreshStrobeN` is 1 and `refreshAddr` is 0x0000 whenever no fetch is in progress.
- R2: A clock edge during which `fetchCycle` is 1 and `tState` equals 4 increments counter bits 6:0 by one. The new value can be read in the following cycle. The counter does not change on any other edge, including T-states 1 to 3 and a `tState` of 4 with `fetchCycle` at 0.
- R3: An increment never changes counter bit 7.
- R4: Bits 6:0 wrap from 127 to 0 with bit 7 held, so 0x7F becomes 0x00 and 0xFF becomes 0x80.
- R5: A clock edge with `loadStrobe` at 1 writes all eight bits of `loadData` into the counter, bit 7 included.
- R6: When a load and an increment fall on the same edge, the counter takes `loadData` unchanged and is not incremented.
- R7: `refreshStrobeN` is 0 exactly when `fetchCycle` is 1 and `tState` is 3 or 4, in the same cycle and with no added cycles. Otherwise it is 1.
- R8: While `refreshStrobeN` is 0, `refreshAddr` equals {`vectorReg`, counter}, with the vector in bits 15:8 and the counter in bits 7:0. At all other times it is 0x0000.
- R9: `readData` equals the full 8-bit counter in the same cycle when `readReq` is 1, and it is 0x00 when `readReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchCycle | input | 1 | High during an opcode-fetch machine cycle |
| tState | input | 3 | Current T-state number, 1 to 4 (0 when idle) |
| loadStrobe | input | 1 | Writes `loadData` into the counter on the clock edge |
| loadData | input | 8 | Value to load |
| readReq | input | 1 | Requests read-back of the counter |
| vectorReg | input | 8 | Interrupt-vector register value used as the high address byte |
| refreshAddr | output | 16 | Refresh address: vector byte above the counter byte |
| refreshStrobeN | output | 1 | Active-low refresh strobe |
| readData | output | 8 | Counter value when read is requested, otherwise 0 |

## Verification
The strobe, the refresh address and the read-back are combinational, so they are due in the same cycle as the T-state, vector or read request that drives them. The bench changes inputs on the falling edge and samples these outputs one nanosecond later. A load or an increment is applied on the rising edge and can be seen one cycle later. The bench therefore reads the counter back after that edge has passed, and it updates its arithmetic model only after the edge. The sweep loads all 256 values. For each value it runs a full four-state fetch, which covers both wrap points and every setting of bit 7, and then runs a long chain of fetches across a wrap.

// File: rtl/mem_refresh_pkg.sv
package mem_refresh_pkg;

  typedef struct packed {
    logic doLoad;
    logic doInc;
    logic driveRefresh;
  } refreshStrobes_t;

endpackage

// File: rtl/mem_refresh_ctrl.sv
module mem_refresh_ctrl
  import mem_refresh_pkg::*;
#(
  parameter int TSTATE_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fetchCycle,
  input  logic [TSTATE_W-1:0] tState,
  input  logic                loadStrobe,
  output refreshStrobes_t     strobes
);

  localparam logic [TSTATE_W-1:0] T3 = TSTATE_W'(3);
  localparam logic [TSTATE_W-1:0] T4 = TSTATE_W'(4);

  logic inRefreshWindow;
  logic lastFetchState;

  always_comb begin
    inRefreshWindow      = fetchCycle && (tState == T3 || tState == T4);
    lastFetchState       = fetchCycle && (tState == T4);
    strobes.doLoad       = loadStrobe;
    strobes.doInc        = lastFetchState && !loadStrobe;
    strobes.driveRefresh = inRefreshWindow;
  end

  AST_INC_NOT_WITH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.doInc && strobes.doLoad)); // R6

  AST_INC_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doInc |-> strobes.driveRefresh); // R2

endmodule

// File: rtl/mem_refresh_dp.sv
module mem_refresh_dp
  import mem_refresh_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  refreshStrobes_t    strobes,
  input  logic [REG_W-1:0]   loadData,
  input  logic               readReq,
  input  logic [REG_W-1:0]   vectorReg,
  output logic [2*REG_W-1:0] refreshAddr,
  output logic [REG_W-1:0]   readData
);

  localparam int CNT_W = REG_W - 1;

  logic [REG_W-1:0] counterQ;
  logic [CNT_W-1:0] lowNext;

  always_comb lowNext = counterQ[CNT_W-1:0] + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      counterQ <= '0;
    end else if (strobes.doLoad) begin
      counterQ <= loadData;
    end else if (strobes.doInc) begin
      counterQ <= {counterQ[REG_W-1], lowNext};
    end
  end

  always_comb begin
    refreshAddr = strobes.driveRefresh ? {vectorReg, counterQ} : '0;
    readData    = readReq ? counterQ : '0;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> counterQ == '0); // R1

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doInc && !strobes.doLoad) |=>
      counterQ[CNT_W-1:0] == CNT_W'($past(counterQ[CNT_W-1:0]) + 1)); // R2

  AST_TOP_BIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doInc && !strobes.doLoad) |=>
      counterQ[REG_W-1] == $past(counterQ[REG_W-1])); // R3

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doLoad |=> counterQ == $past(loadData)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.doLoad && !strobes.doInc) |=> $stable(counterQ)); // R2

endmodule

// File: rtl/mem_refresh_counter.sv
module mem_refresh_counter
  import mem_refresh_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int TSTATE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchCycle,
  input  logic [TSTATE_W-1:0] tState,
  input  logic               loadStrobe,
  input  logic [REG_W-1:0]   loadData,
  input  logic               readReq,
  input  logic [REG_W-1:0]   vectorReg,
  output logic [2*REG_W-1:0] refreshAddr,
  output logic               refreshStrobeN,
  output logic [REG_W-1:0]   readData
);

  refreshStrobes_t strobes;

  mem_refresh_ctrl #(.TSTATE_W(TSTATE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchCycle (fetchCycle),
    .tState     (tState),
    .loadStrobe (loadStrobe),
    .strobes    (strobes)
  );

  mem_refresh_dp #(.REG_W(REG_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .loadData    (loadData),
    .readReq     (readReq),
    .vectorReg   (vectorReg),
    .refreshAddr (refreshAddr),
    .readData    (readData)
  );

  always_comb refreshStrobeN = !strobes.driveRefresh;

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    refreshStrobeN |-> refreshAddr == '0); // R8

  AST_ADDR_HIGH_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    !refreshStrobeN |-> refreshAddr[2*REG_W-1:REG_W] == vectorReg); // R8

  AST_STROBE_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    !refreshStrobeN |-> fetchCycle); // R7

  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !readReq |-> readData == '0); // R9

endmodule

// File: tb/mem_refresh_counter_bench.sv
module mem_refresh_counter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchCycle = 1'b0;
  logic [2:0]  tState = 3'd0;
  logic        loadStrobe = 1'b0;
  logic [7:0]  loadData = 8'h00;
  logic        readReq = 1'b0;
  logic [7:0]  vectorReg = 8'h00;
  logic [15:0] refreshAddr;
  logic        refreshStrobeN;
  logic [7:0]  readData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model = 8'h00;

  always #2 clk = ~clk;

  mem_refresh_counter u_mem_refresh_counter (
    .clk(clk), .rstN(rstN), .fetchCycle(fetchCycle), .tState(tState),
    .loadStrobe(loadStrobe), .loadData(loadData), .readReq(readReq),
    .vectorReg(vectorReg), .refreshAddr(refreshAddr),
    .refreshStrobeN(refreshStrobeN), .readData(readData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bumped(input logic [7:0] v);
    return {v[7], 7'((v[6:0] + 7'd1) % 128)};
  endfunction

  task automatic readBack(input string req);
    @(negedge clk);
    readReq = 1'b1;
    #1 check(req, {24'd0, readData}, {24'd0, model});
    readReq = 1'b0;
    #1 check("R9 read idle", {24'd0, readData}, 32'd0);
  endtask

  task automatic doLoad(input logic [7:0] v);
    @(negedge clk);
    loadStrobe = 1'b1;
    loadData = v;
    @(negedge clk);
    loadStrobe = 1'b0;
    model = v;
  endtask

  // One fetch cycle: T1..T4, checking strobe and address in each state
  task automatic doFetch(input logic [7:0] vec);
    for (int t = 1; t <= 4; t++) begin
      @(negedge clk);
      fetchCycle = 1'b1;
      tState = 3'(t);
      vectorReg = vec;
      #1;
      if (t >= 3) begin
        check("R7 strobe in T3/T4", {31'd0, refreshStrobeN}, 32'd0);
        check("R8 address", {16'd0, refreshAddr}, {16'd0, vec, model});
      end else begin
        check("R7 strobe in T1/T2", {31'd0, refreshStrobeN}, 32'd1);
        check("R8 address idle", {16'd0, refreshAddr}, 32'd0);
      end
    end
    @(negedge clk);
    fetchCycle = 1'b0;
    tState = 3'd0;
    model = bumped(model);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 strobe in reset", {31'd0, refreshStrobeN}, 32'd1);
    check("R1 address in reset", {16'd0, refreshAddr}, 32'd0);
    readReq = 1'b1;
    #1 check("R1 counter in reset", {24'd0, readData}, 32'd0);
    readReq = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    readBack("R1 counter after reset");

    // R2: T4 without fetch flag does nothing
    @(negedge clk);
    tState = 3'd4;
    #1 check("R7 no strobe without fetch", {31'd0, refreshStrobeN}, 32'd1);
    @(negedge clk);
    tState = 3'd0;
    readBack("R2 no increment without fetch");

    // Sweep every load value through a full fetch (R2, R3, R4, R5)
    for (int v = 0; v < 256; v++) begin
      doLoad(8'(v));
      readBack("R5 loaded value");
      doFetch(8'(255 - v));
      readBack((v[6:0] == 7'h7F) ? "R4 wrap holds bit 7" : "R2 R3 increment");
    end

    // R4: long chain across the wrap with bit 7 set
    doLoad(8'hFC);
    for (int n = 0; n < 130; n++) doFetch(8'(n));
    readBack("R4 chain result");

    // R6: load on the T4 edge wins over the increment
    doLoad(8'h10);
    for (int t = 1; t <= 4; t++) begin
      @(negedge clk);
      fetchCycle = 1'b1;
      tState = 3'(t);
      if (t == 4) begin
        loadStrobe = 1'b1;
        loadData = 8'hA5;
      end
    end
    @(negedge clk);
    fetchCycle = 1'b0;
    tState = 3'd0;
    loadStrobe = 1'b0;
    model = 8'hA5;
    readBack("R6 load beats increment");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual running expected done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule